// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits next to a small processor core and chooses which of five hardware request lines gets serviced next. One line cannot be masked and is captured on its rising edge. Three maskable lines each branch to a fixed vector address. One maskable general line has no address of its own: the block runs an acknowledge handshake and the requesting device places a vector byte on a bus.

When a request is accepted, the block issues a single-cycle take strobe together with a 16-bit vector. The core then saves its program counter and branches to that vector. Acceptance turns off maskable interrupts until the core signals a return from interrupt or sets the enable again. Any request that loses arbitration, or is held back while interrupts are off, stays pending and competes again later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `take_o` and `inta_o` are 0, maskable interrupts are disabled and all three mask bits are set, so no maskable request is accepted until software enables and unmasks it.
- R2: A rising edge on `nmi_i` is latched and accepted even when interrupts are disabled or masked. A one-cycle pulse is enough. Its vector is 0x0024.
- R3: The fixed priority, from highest to lowest, is `nmi_i`, `vreq_i[2]`, `vreq_i[1]`, `vreq_i[0]`, `ext_req_i`. At most one source is granted per decision.
- R4: Accepting `vreq_i[2]`, `vreq_i[1]` or `vreq_i[0]` gives vector 0x003C, 0x0034 or 0x002C respectively. `take_o` rises on the clock edge after the request is first seen while eligible.
- R5: A set bit `i` of the mask register blocks `vreq_i[i]`. A pulse on `mask_wr_i` loads `mask_i` into the mask register, and the new mask takes effect from the next decision.
- R6: While the enable flag is clear (`ie_clr_i`), all maskable lines, including `ext_req_i`, are ignored.
- R7: Every acceptance clears the enable flag, so held maskable requests are ignored. After a `ret_i` or `ie_set_i` pulse, a request still held is taken on the following clock edge.
- R8: When `ext_req_i` wins, `inta_o` pulses for exactly one cycle. `ext_vec_i` is sampled in the cycle after that pulse. `take_o` then pulses with vector {8'h00, `ext_vec_i`}.
- R9: `take_o` and `inta_o` are never high together. A held request produces exactly one take pulse per acceptance.
- R10: A request that arrives during the acknowledge handshake stays pending. If it is `nmi_i`, it is taken on the edge right after the external take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge captured |
| vreq_i | input | 3 | Maskable vectored request levels, bit 2 highest |
| ext_req_i | input | 1 | Maskable general request level, externally vectored |
| ext_vec_i | input | 8 | Vector byte supplied by the device after acknowledge |
| ie_set_i | input | 1 | Enable maskable interrupts |
| ie_clr_i | input | 1 | Disable maskable interrupts |
| ret_i | input | 1 | Return from interrupt, re-enables maskable interrupts |
| mask_wr_i | input | 1 | Load the mask register |
| mask_i | input | 3 | New mask bits, 1 blocks the matching vreq line |
| take_o | output | 1 | One-cycle strobe: branch to vector_o |
| inta_o | output | 1 | One-cycle interrupt acknowledge for the general line |
| vector_o | output | 16 | Branch address, valid while take_o is high |

## Verification
The assertions assume that every input is synchronous to `clk_i` and changes only between edges. They also assume that `ext_req_i` and `ext_vec_i` stay stable from the acknowledge pulse until the take strobe, because the external vector is only meaningful under that condition. The bench drives every input on the falling edge. For the general line it holds the request and the vector byte constant across the whole handshake. It releases requests only after the matching take has been observed. The NMI line is given one-cycle pulses so that edge capture is exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ACK   = 2'd1,
    SEQ_FETCH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q, pend_q, rise;

  assign rise   = nmi_i & ~nmi_q;
  assign pend_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= pend_o & ~take_i;
    end
  end

  // R2
  nmi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !take_i) |=> pend_o);

  // R2
  nmi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !nmi_i) |=> !pend_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_VEC = 3
) (
  input  logic               idle_i,
  input  logic               ie_i,
  input  logic               nmi_pend_i,
  input  logic [NUM_VEC-1:0] vreq_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic               ext_req_i,
  output logic               nmi_win_o,
  output logic [NUM_VEC-1:0] vec_win_o,
  output logic               ext_win_o
);
  logic [NUM_VEC-1:0] elig;
  logic               open_slot;

  assign elig      = vreq_i & ~mask_i & {NUM_VEC{ie_i}};
  assign nmi_win_o = idle_i & nmi_pend_i;
  assign open_slot = idle_i & ~nmi_pend_i;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_win
    if (i == NUM_VEC - 1) begin : g_top
      assign vec_win_o[i] = open_slot & elig[i];
    end else begin : g_low
      assign vec_win_o[i] = open_slot & elig[i] & ~|elig[NUM_VEC-1:i+1];
    end
  end

  assign ext_win_o = open_slot & ie_i & ext_req_i & ~|elig;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 3,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned EXT_W    = 8,
  parameter int unsigned VEC_BASE = 16'h002C,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic               ret_i,
  input  logic               mask_wr_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic               nmi_win_i,
  input  logic [NUM_VEC-1:0] vec_win_i,
  input  logic               ext_win_i,
  input  logic [EXT_W-1:0]   ext_vec_i,
  output logic               idle_o,
  output logic               ie_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic               take_o,
  output logic               inta_o,
  output logic [VEC_W-1:0]   vector_o
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(VEC_BASE - VEC_STEP);

  seq_state_e         state_q, state_d;
  logic               ie_q, ie_d;
  logic [NUM_VEC-1:0] mask_q;
  logic               take_q, take_d, inta_q, inta_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               accept;
  logic [VEC_W-1:0]   fixed_vec;

  assign accept = nmi_win_i | (|vec_win_i) | ext_win_i;
  assign idle_o = (state_q == SEQ_IDLE);
  assign ie_o   = ie_q;
  assign mask_o = mask_q;

  always_comb begin
    fixed_vec = NMI_VEC;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (!nmi_win_i && vec_win_i[i]) fixed_vec = VEC_W'(VEC_BASE + VEC_STEP * i);
    end
  end

  always_comb begin
    state_d = state_q;
    take_d  = 1'b0;
    inta_d  = 1'b0;
    vec_d   = vec_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (ext_win_i) begin
          inta_d  = 1'b1;
          state_d = SEQ_ACK;
        end else if (accept) begin
          take_d = 1'b1;
          vec_d  = fixed_vec;
        end
      end
      SEQ_ACK:  state_d = SEQ_FETCH;
      SEQ_FETCH: begin
        take_d  = 1'b1;
        vec_d   = {{(VEC_W-EXT_W){1'b0}}, ext_vec_i};
        state_d = SEQ_IDLE;
      end
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    ie_d = ie_q;
    if (accept)                 ie_d = 1'b0;
    else if (ie_clr_i)          ie_d = 1'b0;
    else if (ie_set_i || ret_i) ie_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ie_q    <= 1'b0;
      mask_q  <= '1;
      take_q  <= 1'b0;
      inta_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      ie_q    <= ie_d;
      if (mask_wr_i) mask_q <= mask_i;
      take_q  <= take_d;
      inta_q  <= inta_d;
      vec_q   <= vec_d;
    end
  end

  assign take_o   = take_q;
  assign inta_o   = inta_q;
  assign vector_o = vec_q;

  // R8
  inta_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o);

  // R8
  inta_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> ##1 take_o);

  // R7
  accept_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ie_q);

  // R6
  maskable_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|vec_win_i) || ext_win_i) |-> ie_q);

  // R5
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_win_i & mask_q) == '0);

  // R9
  take_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_o && inta_o));

  // R3
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_win_i, vec_win_i, ext_win_i}));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_VEC  = 3,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned EXT_W    = 8,
  parameter int unsigned VEC_BASE = 16'h002C,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nmi_i,
  input  logic [NUM_VEC-1:0] vreq_i,
  input  logic               ext_req_i,
  input  logic [EXT_W-1:0]   ext_vec_i,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic               ret_i,
  input  logic               mask_wr_i,
  input  logic [NUM_VEC-1:0] mask_i,
  output logic               take_o,
  output logic               inta_o,
  output logic [VEC_W-1:0]   vector_o
);
  logic               nmi_pend, nmi_win, ext_win, idle, ie;
  logic [NUM_VEC-1:0] vec_win, mask;

  irq_nmi_edge i_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (nmi_win),
    .pend_o (nmi_pend)
  );

  irq_pick #(.NUM_VEC(NUM_VEC)) i_pick (
    .idle_i     (idle),
    .ie_i       (ie),
    .nmi_pend_i (nmi_pend),
    .vreq_i     (vreq_i),
    .mask_i     (mask),
    .ext_req_i  (ext_req_i),
    .nmi_win_o  (nmi_win),
    .vec_win_o  (vec_win),
    .ext_win_o  (ext_win)
  );

  irq_seq #(
    .NUM_VEC  (NUM_VEC),
    .VEC_W    (VEC_W),
    .EXT_W    (EXT_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ie_set_i  (ie_set_i),
    .ie_clr_i  (ie_clr_i),
    .ret_i     (ret_i),
    .mask_wr_i (mask_wr_i),
    .mask_i    (mask_i),
    .nmi_win_i (nmi_win),
    .vec_win_i (vec_win),
    .ext_win_i (ext_win),
    .ext_vec_i (ext_vec_i),
    .idle_o    (idle),
    .ie_o      (ie),
    .mask_o    (mask),
    .take_o    (take_o),
    .inta_o    (inta_o),
    .vector_o  (vector_o)
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 1'b0, ext_req = 1'b0;
  logic [2:0]  vreq = '0, mask_in = '0;
  logic [7:0]  ext_vec = '0;
  logic        ie_set = 1'b0, ie_clr = 1'b0, ret = 1'b0, mask_wr = 1'b0;
  logic        take, inta;
  logic [15:0] vector;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .vreq_i(vreq), .ext_req_i(ext_req),
    .ext_vec_i(ext_vec), .ie_set_i(ie_set), .ie_clr_i(ie_clr), .ret_i(ret),
    .mask_wr_i(mask_wr), .mask_i(mask_in), .take_o(take), .inta_o(inta), .vector_o(vector)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_quiet(input string req);
    chk(take == 1'b0, req, take, 0);
    chk(inta == 1'b0, req, inta, 0);
  endtask

  task automatic chk_take(input string req, input int exp_vec);
    chk(take == 1'b1, req, take, 1);
    chk(vector == 16'(exp_vec), req, vector, exp_vec);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state, requests ignored while disabled
    chk_quiet("R1");
    vreq = 3'b100; ext_req = 1'b1;
    tick(); chk_quiet("R1");
    tick(); chk_quiet("R1");
    ext_req = 1'b0;
    ie_set = 1'b1; tick(); ie_set = 1'b0;
    tick(); chk_quiet("R1 mask reset");
    tick(); chk_quiet("R1 mask reset");
    // R5: unmask takes effect on next decision
    mask_wr = 1'b1; mask_in = 3'b000; tick(); mask_wr = 1'b0;
    chk_quiet("R5");
    tick(); chk_take("R5 R4", 16'h003C);
    // R7: held request ignored until return
    vreq = 3'b010;
    tick(); chk_quiet("R7 R9");
    tick(); chk_quiet("R7");
    ret = 1'b1; tick(); ret = 1'b0;
    chk_quiet("R7");
    tick(); chk_take("R7", 16'h0034);
    vreq = '0;
    // R6: disable blocks ext line
    ret = 1'b1; tick(); ret = 1'b0;
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
    ext_req = 1'b1; ext_vec = 8'hA5;
    tick(); chk_quiet("R6");
    tick(); chk_quiet("R6");
    // R10: NMI during handshake
    ie_set = 1'b1; tick(); ie_set = 1'b0;
    tick();
    chk(inta == 1'b1, "R8 R10", inta, 1);
    nmi = 1'b1;
    tick(); nmi = 1'b0;
    chk_quiet("R8 R10");
    tick(); chk_take("R8 R10", 16'h00A5);
    ext_req = 1'b0;
    tick(); chk_take("R10 R2", 16'h0024);
    tick(); chk_quiet("R9");

    // sweep: all masks x all request patterns
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 32; r++) begin
        int exp_vec;
        bit is_ext, none;
        logic [2:0] el;
        el      = 3'(r >> 1) & ~3'(m);
        is_ext  = 1'b0; none = 1'b0; exp_vec = 0;
        if (r[4])       exp_vec = 16'h0024;
        else if (el[2]) exp_vec = 16'h003C;
        else if (el[1]) exp_vec = 16'h0034;
        else if (el[0]) exp_vec = 16'h002C;
        else if (r[0])  begin is_ext = 1'b1; exp_vec = (m * 32 + r) & 8'hFF; end
        else            none = 1'b1;
        mask_wr = 1'b1; mask_in = 3'(m); ie_set = 1'b1;
        tick();
        mask_wr = 1'b0; ie_set = 1'b0;
        nmi = r[4]; vreq = 3'(r >> 1); ext_req = r[0]; ext_vec = 8'(m * 32 + r);
        tick();
        nmi = 1'b0;
        if (is_ext) begin
          chk(inta == 1'b1 && take == 1'b0, "R8 R3", {inta, take}, 2'b10);
          tick(); chk_quiet("R8");
          tick(); chk_take("R8 R3", exp_vec);
        end else if (none) begin
          chk_quiet("R5");
        end else begin
          chk_take(r[4] ? "R2 R3" : "R3 R4 R5", exp_vec);
        end
        tick(); chk_quiet("R7 R9");
        vreq = '0; ext_req = 1'b0;
        ret = 1'b1; tick(); ret = 1'b0;
        tick();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule